// File: doc/BRIEF.md
# Serial Output Stream Enable Controller

This block sits between a TDM switch core and the output pads of a group of serial streams. Each stream carries frames of channel time slots, each slot holding several bits sent most significant bit first, and each bit lasting a fixed number of system clocks. The block decides, clock by clock, whether each stream pin carries data or goes quiet. It forwards the serial data after a selectable delay. The delay lets the output edge be moved earlier than the nominal bit boundary by 0, 2, 4 or 6 system clocks.

Four sources gate the outputs. In falling order of precedence they are the reset input, an output-drive-enable input, a standby input that software controls, and a per-channel enable read from the connection memory. A strap input picks one of two output styles and is captured only while reset is held. In the internal style the block deasserts each stream's pad enable for disabled channels. In the external style the pads always drive. A per-stream control output then marks each enabled slot, so that an external buffer can do the tristating.

Top module: `tdm_out_enable_ctrl`

## Requirements
- R1: The style strap is resynchronised and captured only while `rst_n` is low, so `rst_n` must stay low for at least 3 clocks. A strap of 1 selects the internal style and 0 the external style. Changes to the strap after reset release have no effect until the next reset.
- R2: In the internal style, when globally permitted, `st_oe[s]` equals the held channel enable of the slot being output, and `ext_ctl` stays 0 at all times.
- R3: In the external style, `st_oe` is all ones at all times. When globally permitted, `ext_ctl[s]` equals the held channel enable of the slot being output.
- R4: While `rst_n` is low, every stream is disabled. The internal style gives `st_oe`=0, the external style gives `st_oe`=1, `st_out`=1 is driven in both styles, and `ext_ctl` is 0. This overrides every other input.
- R5: With `rst_n` high and `drive_en` low, the outputs take the disabled state of R4 whatever `standby_n` and the channel enables are.
- R6: With `rst_n` and `drive_en` high and `standby_n` low, the outputs take the disabled state of R4 whatever the channel enables are.
- R7: A slot lasts BITS_PER_CH*CLKS_PER_BIT clocks. `ch_en` is sampled on the first clock of each slot and held for the whole slot, so changes later in the slot are ignored.
- R8: `st_out[s]` repeats `ser_in[s]` after 7 - 2*`adv_sel` clocks whenever the stream carries data. It carries data when globally permitted and, in the internal style, when the slot is also enabled. Otherwise `st_out[s]` is 1.
- R9: `ext_ctl` and the held enable travel through the same delay as the data, so the control marks exactly the slot whose bits are on `st_out`.
- R10: A high `frame_pulse` marks the current clock as the first clock of a slot at any time, even in the middle of a slot. Counting continues from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; highest-priority disable and strap capture window |
| tri_strap | input | 1 | Asynchronous style strap: 1 internal tristate, 0 external buffer control |
| drive_en | input | 1 | Output drive enable, high permits output |
| standby_n | input | 1 | Standby control, high permits output |
| adv_sel | input | 2 | Output advancement: earlier by 2*adv_sel clocks |
| frame_pulse | input | 1 | Marks the first clock of a slot (frame start) |
| ser_in | input | NUM_STREAMS | Serial data from the switch core, one bit per stream |
| ch_en | input | NUM_STREAMS | Per-channel enable from the connection memory, per stream |
| st_out | output | NUM_STREAMS | Stream data toward the pads |
| st_oe | output | NUM_STREAMS | Pad output enable per stream |
| ext_ctl | output | NUM_STREAMS | External buffer control per stream |

## Verification
Random data and per-clock random channel enables run under both straps, all four advancement settings and all four combinations of `drive_en` and `standby_n`. The data patterns show whether each delay is right. The enables change inside a slot, which shows whether only the first-clock sample is held. The control combinations show whether each priority level masks the ones below it. Further runs toggle the strap after release, to separate a captured style from a live one. Another run inserts a frame pulse in the middle of a slot, to show that the slot counter realigns.

// File: rtl/tdm_out_enable_ctrl.sv
module tdm_out_enable_ctrl #(
  parameter int NUM_STREAMS  = 16,
  parameter int BITS_PER_CH  = 8,
  parameter int CLKS_PER_BIT = 8,
  parameter int ADV_LEVELS   = 4,
  parameter int ADV_STEP     = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tri_strap,
  input  logic                          drive_en,
  input  logic                          standby_n,
  input  logic [$clog2(ADV_LEVELS)-1:0] adv_sel,
  input  logic                          frame_pulse,
  input  logic [NUM_STREAMS-1:0]        ser_in,
  input  logic [NUM_STREAMS-1:0]        ch_en,
  output logic [NUM_STREAMS-1:0]        st_out,
  output logic [NUM_STREAMS-1:0]        st_oe,
  output logic [NUM_STREAMS-1:0]        ext_ctl
);
  localparam int SLOT_CLKS = BITS_PER_CH * CLKS_PER_BIT;
  localparam int CW        = $clog2(SLOT_CLKS);
  localparam int SW        = $clog2(ADV_LEVELS);
  localparam int MAX_ADV   = ADV_STEP * (ADV_LEVELS - 1);

  logic strap_s1, strap_s2, tri_int_q;

  // R1: strap resynchronised, captured only during reset
  always_ff @(posedge clk) begin
    strap_s1 <= tri_strap;
    strap_s2 <= strap_s1;
    if (!rst_n) tri_int_q <= strap_s2;
  end

  logic [CW-1:0] cnt, cur_pos;
  logic [NUM_STREAMS-1:0] en_hold, en_now;
  logic slot_first;

  assign cur_pos    = frame_pulse ? '0 : cnt;
  assign slot_first = (cur_pos == '0);
  assign en_now     = slot_first ? ch_en : en_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      en_hold <= '0;
    end else begin
      cnt <= (cur_pos == CW'(SLOT_CLKS - 1)) ? '0 : cur_pos + 1'b1;
      if (slot_first) en_hold <= ch_en;
    end
  end

  logic [NUM_STREAMS-1:0] dl_d [MAX_ADV+1];
  logic [NUM_STREAMS-1:0] dl_e [MAX_ADV+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= MAX_ADV; k++) begin
        dl_d[k] <= '0;
        dl_e[k] <= '0;
      end
    end else begin
      dl_d[0] <= ser_in;
      dl_e[0] <= en_now;
      for (int k = 1; k <= MAX_ADV; k++) begin
        dl_d[k] <= dl_d[k-1];
        dl_e[k] <= dl_e[k-1];
      end
    end
  end

  logic [NUM_STREAMS-1:0] tap_d, tap_e, out_d, out_e;

  always_comb begin
    tap_d = dl_d[MAX_ADV];
    tap_e = dl_e[MAX_ADV];
    for (int k = 1; k < ADV_LEVELS; k++) begin
      if (adv_sel == SW'(k)) begin
        tap_d = dl_d[MAX_ADV - ADV_STEP * k];
        tap_e = dl_e[MAX_ADV - ADV_STEP * k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_d <= '0;
      out_e <= '0;
    end else begin
      out_d <= tap_d;
      out_e <= tap_e;
    end
  end

  logic glob;
  logic [NUM_STREAMS-1:0] pass;

  assign glob    = rst_n & drive_en & standby_n;
  assign pass    = {NUM_STREAMS{glob}} & (tri_int_q ? out_e : {NUM_STREAMS{1'b1}});
  assign st_out  = out_d | ~pass;
  assign st_oe   = tri_int_q ? ({NUM_STREAMS{glob}} & out_e) : {NUM_STREAMS{1'b1}};
  assign ext_ctl = (!tri_int_q && glob) ? out_e : '0;
endmodule

// File: rtl/tdm_out_enable_ctrl_chk.sv
module tdm_out_enable_ctrl_chk #(
  parameter int NUM_STREAMS = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   drive_en,
  input logic                   standby_n,
  input logic                   tri_int_q,
  input logic [NUM_STREAMS-1:0] st_out,
  input logic [NUM_STREAMS-1:0] st_oe,
  input logic [NUM_STREAMS-1:0] ext_ctl
);
  always @(negedge clk)
    if (!rst_n) AST_RESET_CTL_LOW: assert (ext_ctl == '0); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(tri_int_q)); // R1

  AST_INT_NO_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    tri_int_q |-> ext_ctl == '0); // R2

  AST_EXT_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_int_q |-> st_oe == '1); // R3

  AST_DRIVE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (ext_ctl == '0 && st_out == '1)); // R5

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |-> (ext_ctl == '0 && st_out == '1)); // R6

  AST_CTL_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ctl != '0 |-> (drive_en && standby_n && !tri_int_q)); // R9
endmodule

bind tdm_out_enable_ctrl tdm_out_enable_ctrl_chk #(.NUM_STREAMS(NUM_STREAMS)) u_chk (
  .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .standby_n(standby_n),
  .tri_int_q(tri_int_q), .st_out(st_out), .st_oe(st_oe), .ext_ctl(ext_ctl)
);

// File: tb/test_tdm_out_enable_ctrl.sv
module test_tdm_out_enable_ctrl;
  localparam int NS   = 2;
  localparam int SLOT = 8;
  localparam int FRAME = 32;

  logic clk = 1'b0;
  logic rst_n, tri_strap, drive_en, standby_n, frame_pulse;
  logic [1:0] adv_sel;
  logic [NS-1:0] ser_in, ch_en, st_out, st_oe, ext_ctl;

  always #10 clk = ~clk;

  tdm_out_enable_ctrl #(.NUM_STREAMS(NS), .BITS_PER_CH(2), .CLKS_PER_BIT(4),
                        .ADV_LEVELS(4), .ADV_STEP(2)) i_tdm_out_enable_ctrl (
    .clk(clk), .rst_n(rst_n), .tri_strap(tri_strap), .drive_en(drive_en),
    .standby_n(standby_n), .adv_sel(adv_sel), .frame_pulse(frame_pulse),
    .ser_in(ser_in), .ch_en(ch_en), .st_out(st_out), .st_oe(st_oe), .ext_ctl(ext_ctl));

  int n_chk = 0, n_bad = 0, pc = 0;
  int first_live = 0, rst_cycles = 0, mcnt = 0;
  logic exp_int;
  logic force_fp = 1'b0;
  logic [NS-1:0] mhold = '0;
  logic [NS-1:0] hd [0:4095];
  logic [NS-1:0] he [0:4095];
  string seg = "";

  always @(posedge clk) begin
    pc <= pc + 1;
    if (!rst_n) rst_cycles <= rst_cycles + 1;
  end

  task automatic cmp(string tag, logic [NS-1:0] act, logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, pc, act, exp);
    end
  endtask

  task automatic check_now();
    logic [NS-1:0] d, e, pass, xoe, xctl;
    logic g;
    int src;
    if (!rst_n) begin
      if (rst_cycles >= 3) begin
        cmp("R4 oe", st_oe, exp_int ? '0 : '1);
        cmp("R4 out", st_out, '1);
        cmp("R4 ctl", ext_ctl, '0);
      end
      return;
    end
    src = pc - (7 - 2 * int'(adv_sel));
    d = (src >= first_live) ? hd[src] : '0;
    e = (src >= first_live) ? he[src] : '0;
    g = drive_en & standby_n;
    if (exp_int) begin
      xoe = g ? e : '0; pass = xoe; xctl = '0;
    end else begin
      xoe = '1; pass = g ? '1 : '0; xctl = g ? e : '0;
    end
    cmp($sformatf("%s oe %s", seg, !drive_en ? "R5" : !standby_n ? "R6" :
                  exp_int ? "R2 R7" : "R3 R7"), st_oe, xoe);
    cmp($sformatf("%s out R8 adv=%0d", seg, adv_sel), st_out, d | ~pass);
    cmp($sformatf("%s ctl %s", seg, exp_int ? "R2" : "R9"), ext_ctl, xctl);
  endtask

  task automatic step();
    int k, cur;
    logic [NS-1:0] eff;
    @(negedge clk);
    check_now();
    k = pc + 1;
    ser_in = NS'($urandom);
    ch_en  = NS'($urandom);
    if (rst_n) begin
      frame_pulse = (((k - first_live) % FRAME) == 0) || force_fp;
      cur = frame_pulse ? 0 : mcnt;
      eff = (cur == 0) ? ch_en : mhold;
      if (cur == 0) mhold = ch_en;
      mcnt = (cur == SLOT - 1) ? 0 : cur + 1;
      hd[k] = ser_in;
      he[k] = eff;
    end else begin
      frame_pulse = 1'b0;
    end
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 1'b0; tri_strap = strap; exp_int = strap;
    rst_cycles = 0; mcnt = 0; mhold = '0;
    for (int i = 0; i < 10; i++) step();
    @(negedge clk);
    check_now();
    rst_n = 1'b1;
    first_live = pc + 1;
    frame_pulse = 1'b1;
    ser_in = NS'($urandom); ch_en = NS'($urandom);
    hd[first_live] = ser_in; he[first_live] = ch_en;
    mhold = ch_en; mcnt = 1;
  endtask

  initial begin
    rst_n = 1'b0; tri_strap = 1'b1; exp_int = 1'b1; drive_en = 1'b1; standby_n = 1'b1;
    adv_sel = 2'd0; frame_pulse = 1'b0; ser_in = '0; ch_en = '0;
    for (int m = 0; m < 2; m++) begin
      do_reset(m == 0);
      seg = "";
      for (int a = 0; a < 4; a++) begin
        for (int c = 0; c < 4; c++) begin
          adv_sel = 2'(a);
          drive_en = ~c[1]; standby_n = ~c[0];
          for (int i = 0; i < 24; i++) step();
        end
      end
      // R1: strap flips after release, captured style must persist
      seg = "R1"; drive_en = 1'b1; standby_n = 1'b1; adv_sel = 2'd1;
      tri_strap = ~exp_int;
      for (int i = 0; i < 40; i++) step();
      // R10: frame pulse in the middle of a slot realigns slot timing
      seg = "R10"; adv_sel = 2'd2;
      for (int i = 0; i < 3; i++) step();
      force_fp = 1'b1; step(); force_fp = 1'b0;
      for (int i = 0; i < 40; i++) step();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", pc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule